// File: doc/BRIEF.md
# Activity Monitor Read Trap Evaluator

This block decides, in the same cycle that a request arrives, whether software at privilege level 0 or 1 reading one of the activity-monitor registers must be redirected to the hypervisor (level 2). Each of the four monitor register classes has its own one-bit control field. The fields sit in a 64-bit control word that the hypervisor writes. All other bits of that word are hard-wired to zero.

A trap is raised only when all of these hold:
- the selected field is set;
- level 2 is enabled;
- the host-mode bit pair is not both set;
- level 1 runs in 64-bit state;
- level 3 is either absent or has enabled fine-grained trapping;
- the request comes from a level and state this mechanism covers;
- no higher-priority exception already applies to the read.

The block returns a trap flag and a complementary "not trapped here" flag. Together they qualify a valid request. Delivering the exception is left to the surrounding pipeline.

Top module: `amon_rdtrap_eval`

## Requirements
- R1: After reset the control word reads as all zeros.
- R2: A write stores only bits 0, 17, 18 and 49 of the write data. Every other bit reads zero whatever was written. Without a write the word holds its value.
- R3: Request class code 0 selects control bit 0, code 1 selects bit 17, code 2 selects bit 18 and code 3 selects bit 49. A trap is raised when the selected bit is 1 and every enabling condition holds.
- R4: When the selected control bit is 0, the request is never trapped.
- R5: No trap is raised unless level 2 is enabled, level 1 is in 64-bit state (`cfg_l1_wide`=1), and the host-mode pair is not 2'b11.
- R6: When level 3 is present (`cfg_l3_present`=1), a trap also requires `cfg_l3_fg_en`=1. When level 3 is absent, `cfg_l3_fg_en` has no effect.
- R7: A request with `req_hi_prio_exc`=1 is never trapped.
- R8: Requests from level 2 or level 3 (`req_level` 2 or 3) are never trapped. A 32-bit-state request (`req_narrow`=1) may trap only at level 0. A 64-bit request may trap at level 0 or level 1.
- R9: Both outputs depend combinationally on the request in the same cycle. With `req_valid`=0 both are 0. With `req_valid`=1 exactly one of them is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Write strobe for the control word |
| ctl_wr_data | input | 64 | Control word write data |
| ctl_rd_data | output | 64 | Current control word (unused bits zero) |
| req_valid | input | 1 | Read request present this cycle |
| req_class | input | 2 | Monitor register class, codes 0..3 |
| req_level | input | 2 | Privilege level of the requester, 0..3 |
| req_narrow | input | 1 | 1: request issued in 32-bit state |
| req_hi_prio_exc | input | 1 | Read already raises a higher-priority exception |
| cfg_host_pair | input | 2 | Host-mode bit pair |
| cfg_l2_en | input | 1 | Level 2 implemented and enabled in current security state |
| cfg_l1_wide | input | 1 | Level 1 runs in 64-bit state |
| cfg_l3_present | input | 1 | Level 3 implemented |
| cfg_l3_fg_en | input | 1 | Level-3 fine-grained trap enable |
| trap_l2 | output | 1 | Request must trap to level 2 |
| not_trapped | output | 1 | Valid request passes this mechanism |

## Verification
Several properties are checked on every cycle:
- each disabling condition (environment, level 3, higher-priority exception, level 2 or 3 requester, 32-bit state at level 1, all-zero control word) forces the trap low;
- the two outputs are complementary under a valid request and idle otherwise;
- a write lands masked one cycle later, and the word is stable when there is no write.

The class-to-bit mapping can only be shown by the bench's scenarios. So can the positive trap decision when every condition holds, and the fact that `cfg_l3_fg_en` is ignored with level 3 absent. The bench sweeps every combination of field pattern and request and environment input.

// File: rtl/amon_trap_pkg.sv
package amon_trap_pkg;
  localparam int unsigned CTL_W     = 64;
  localparam int unsigned NUM_CLASS = 4;
  localparam int unsigned CLS_W     = $clog2(NUM_CLASS);
  localparam int unsigned LVL_W     = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_TYPE_G1 = 2'd0,
    CLS_CNT_G1  = 2'd1,
    CLS_CNTEN   = 2'd2,
    CLS_CNT_G0  = 2'd3
  } mon_class_e;

  typedef enum logic [LVL_W-1:0] {
    LVL_APP  = 2'd0,
    LVL_OS   = 2'd1,
    LVL_HYP  = 2'd2,
    LVL_MON  = 2'd3
  } priv_lvl_e;

  // Bit position of each class's control field in the control word
  localparam int unsigned FIELD_POS [NUM_CLASS] = '{0, 17, 18, 49};

  function automatic logic [CTL_W-1:0] field_mask();
    logic [CTL_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_CLASS; i++) m[FIELD_POS[i]] = 1'b1;
    return m;
  endfunction

  localparam logic [CTL_W-1:0] CTL_MASK = field_mask();
endpackage

// File: rtl/amon_ctl_reg.sv
module amon_ctl_reg
  import amon_trap_pkg::*;
#(
  parameter int unsigned W = CTL_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] ctl_q
);
  logic [W-1:0] ctl_d;
  logic [W-1:0] mask_w;

  assign mask_w = W'(CTL_MASK);

  // next-state: only implemented field bits are stored
  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) ctl_d = wr_data & mask_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else if (wr_en) ctl_q <= ctl_d;
  end
endmodule

// File: rtl/amon_field_sel.sv
module amon_field_sel
  import amon_trap_pkg::*;
#(
  parameter int unsigned W  = CTL_W,
  parameter int unsigned NC = NUM_CLASS,
  localparam int unsigned CW = (NC > 1) ? $clog2(NC) : 1
) (
  input  logic [W-1:0]  ctl,
  input  logic [CW-1:0] cls,
  output logic          field_on
);
  logic [NC-1:0] fields;

  for (genvar g = 0; g < NC; g++) begin : g_field
    assign fields[g] = ctl[FIELD_POS[g]];
  end

  always_comb begin
    field_on = 1'b0;
    for (int i = 0; i < NC; i++)
      if (cls == CW'(i)) field_on = fields[i];
  end
endmodule

// File: rtl/amon_gate_cond.sv
module amon_gate_cond
  import amon_trap_pkg::*;
(
  input  logic [LVL_W-1:0] level,
  input  logic             narrow,
  input  logic [1:0]       host_pair,
  input  logic             l2_en,
  input  logic             l1_wide,
  input  logic             l3_present,
  input  logic             l3_fg_en,
  output logic             gate_ok
);
  logic env_ok;
  logic l3_ok;
  logic lvl_ok;

  always_comb begin
    env_ok = l2_en && (host_pair != 2'b11) && l1_wide;
    l3_ok  = !l3_present || l3_fg_en;
    unique case (priv_lvl_e'(level))
      LVL_APP: lvl_ok = 1'b1;
      LVL_OS:  lvl_ok = !narrow;
      default: lvl_ok = 1'b0;
    endcase
    gate_ok = env_ok && l3_ok && lvl_ok;
  end
endmodule

// File: rtl/amon_rdtrap_eval.sv
module amon_rdtrap_eval
  import amon_trap_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_wr_en,
  input  logic [CTL_W-1:0]     ctl_wr_data,
  output logic [CTL_W-1:0]     ctl_rd_data,
  input  logic                 req_valid,
  input  logic [CLS_W-1:0]     req_class,
  input  logic [LVL_W-1:0]     req_level,
  input  logic                 req_narrow,
  input  logic                 req_hi_prio_exc,
  input  logic [1:0]           cfg_host_pair,
  input  logic                 cfg_l2_en,
  input  logic                 cfg_l1_wide,
  input  logic                 cfg_l3_present,
  input  logic                 cfg_l3_fg_en,
  output logic                 trap_l2,
  output logic                 not_trapped
);
  logic [CTL_W-1:0] ctl_q;
  logic             field_on;
  logic             gate_ok;

  amon_ctl_reg #(.W(CTL_W)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ctl_wr_en),
    .wr_data (ctl_wr_data),
    .ctl_q   (ctl_q)
  );

  amon_field_sel #(.W(CTL_W), .NC(NUM_CLASS)) u_sel (
    .ctl      (ctl_q),
    .cls      (req_class),
    .field_on (field_on)
  );

  amon_gate_cond u_gate (
    .level      (req_level),
    .narrow     (req_narrow),
    .host_pair  (cfg_host_pair),
    .l2_en      (cfg_l2_en),
    .l1_wide    (cfg_l1_wide),
    .l3_present (cfg_l3_present),
    .l3_fg_en   (cfg_l3_fg_en),
    .gate_ok    (gate_ok)
  );

  always_comb begin
    trap_l2     = req_valid && field_on && gate_ok && !req_hi_prio_exc;
    not_trapped = req_valid && !trap_l2;
  end

  assign ctl_rd_data = ctl_q;
endmodule

// File: rtl/amon_rdtrap_chk.sv
module amon_rdtrap_chk
  import amon_trap_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ctl_wr_en,
  input logic [CTL_W-1:0]     ctl_wr_data,
  input logic [CTL_W-1:0]     ctl_rd_data,
  input logic                 req_valid,
  input logic [CLS_W-1:0]     req_class,
  input logic [LVL_W-1:0]     req_level,
  input logic                 req_narrow,
  input logic                 req_hi_prio_exc,
  input logic [1:0]           cfg_host_pair,
  input logic                 cfg_l2_en,
  input logic                 cfg_l1_wide,
  input logic                 cfg_l3_present,
  input logic                 cfg_l3_fg_en,
  input logic                 trap_l2,
  input logic                 not_trapped
);
  p_write_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_en |=> ctl_rd_data == ($past(ctl_wr_data) & CTL_MASK));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr_en |=> $stable(ctl_rd_data));

  p_zero_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd_data == '0) |-> !trap_l2);

  p_env_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_l2_en || !cfg_l1_wide || cfg_host_pair == 2'b11) |-> !trap_l2);

  p_l3_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_l3_present && !cfg_l3_fg_en) |-> !trap_l2);

  p_hiprio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_hi_prio_exc |-> !trap_l2);

  p_high_lvl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_level[1] || (req_level == 2'd1 && req_narrow)) |-> !trap_l2);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!trap_l2 && !not_trapped));

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $onehot({trap_l2, not_trapped}));
endmodule

bind amon_rdtrap_eval amon_rdtrap_chk u_chk (.*);

// File: tb/amon_rdtrap_eval_tb.sv
module amon_rdtrap_eval_tb;
  localparam logic [63:0] MASK = 64'h0002_0000_0006_0001;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_wr_en;
  logic [63:0] ctl_wr_data;
  logic [63:0] ctl_rd_data;
  logic        req_valid;
  logic [1:0]  req_class;
  logic [1:0]  req_level;
  logic        req_narrow;
  logic        req_hi_prio_exc;
  logic [1:0]  cfg_host_pair;
  logic        cfg_l2_en;
  logic        cfg_l1_wide;
  logic        cfg_l3_present;
  logic        cfg_l3_fg_en;
  logic        trap_l2;
  logic        not_trapped;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  amon_rdtrap_eval u_dut (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog expired: actual cycles %0d expected < 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk64(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic write_ctl(logic [63:0] d);
    @(negedge clk);
    ctl_wr_en   = 1'b1;
    ctl_wr_data = d;
    @(negedge clk);
    ctl_wr_en   = 1'b0;
    ctl_wr_data = ~d;
  endtask

  function automatic logic [63:0] spread(logic [3:0] p);
    logic [63:0] v;
    v = '0;
    v[0] = p[0]; v[17] = p[1]; v[18] = p[2]; v[49] = p[3];
    return v;
  endfunction

  initial begin
    rst_n = 1'b0; ctl_wr_en = 1'b0; ctl_wr_data = '1;
    req_valid = 1'b0; req_class = '0; req_level = '0; req_narrow = 1'b0;
    req_hi_prio_exc = 1'b0; cfg_host_pair = '0; cfg_l2_en = 1'b1;
    cfg_l1_wide = 1'b1; cfg_l3_present = 1'b0; cfg_l3_fg_en = 1'b0;
    repeat (3) @(negedge clk);
    chk64("R1 reset word", ctl_rd_data, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk64("R1 word after release", ctl_rd_data, 64'd0);

    // R2: masking and hold
    write_ctl('1);
    chk64("R2 all-ones write", ctl_rd_data, MASK);
    write_ctl(~MASK);
    chk64("R2 reserved-only write", ctl_rd_data, 64'd0);
    write_ctl(64'hDEAD_BEEF_0123_4567);
    chk64("R2 pattern write", ctl_rd_data, 64'hDEAD_BEEF_0123_4567 & MASK);
    ctl_wr_data = '1;
    repeat (3) @(negedge clk);
    chk64("R2 hold without write", ctl_rd_data, 64'hDEAD_BEEF_0123_4567 & MASK);

    // R9: idle request gives no outputs whatever the word
    write_ctl('1);
    req_valid = 1'b0;
    for (int c = 0; c < 4; c++) begin
      req_class = 2'(c);
      #1;
      chk64("R9 idle outputs", {62'd0, trap_l2, not_trapped}, 64'd0);
    end

    // Exhaustive sweep
    for (int p = 0; p < 16; p++) begin
      write_ctl(spread(4'(p)) | (~MASK & {32'hA5A5_5A5A, 28'(p * 7), 4'(p)}));
      chk64("R2 sweep word", ctl_rd_data, spread(4'(p)));
      req_valid = 1'b1;
      for (int e = 0; e < 4096; e++) begin
        logic fld, env, l3, lvl, exp_t;
        string tag;
        req_class       = e[1:0];
        req_level       = e[3:2];
        req_narrow      = e[4];
        cfg_host_pair   = e[6:5];
        cfg_l2_en       = e[7];
        cfg_l1_wide     = e[8];
        cfg_l3_present  = e[9];
        cfg_l3_fg_en    = e[10];
        req_hi_prio_exc = e[11];
        fld = p[e[1:0]];
        env = cfg_l2_en && cfg_l1_wide && (cfg_host_pair != 2'b11);
        l3  = !cfg_l3_present || cfg_l3_fg_en;
        lvl = (req_level == 2'd0) || (req_level == 2'd1 && !req_narrow);
        exp_t = fld && env && l3 && lvl && !req_hi_prio_exc;
        if (req_hi_prio_exc)  tag = "R7 higher-priority exception";
        else if (!lvl)        tag = "R8 level/state";
        else if (!env)        tag = "R5 environment";
        else if (!l3)         tag = "R6 level-3 enable";
        else if (!fld)        tag = "R4 field clear";
        else                  tag = "R3 class trap";
        #1;
        chk64(tag, {62'd0, trap_l2, not_trapped}, {62'd0, exp_t, !exp_t});
      end
      req_valid = 1'b0;
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule